// File: doc/BRIEF.md
# Torus Dimension-Order Route Computer

This block picks the next hop for one packet header in a three-dimensional torus. Each ring wraps around, so the last node in a ring links back to the first. A header carries the coordinates of the current node and of the destination, the port the packet arrived on, and a three-bit dateline state with one bit per dimension. The block returns three things: the output port, the virtual lane for that hop, and the updated dateline state.

Routing is strictly dimension-ordered. The X offset is resolved first, then Y, then Z. Inside a ring the packet takes the shorter way round. The dateline in each ring is the wrap link between the last coordinate and coordinate 0. When a hop crosses it, the bit for that dimension is set and the hop moves to lane 1. Each dimension's bit starts from zero when the packet enters that dimension. Together these rules break the cyclic buffer dependency that wraparound rings would otherwise create. The ring sizes are parameters.

The block has one register stage with a valid/ready handshake on each side. A router places one instance in front of each input port's buffer.

Top module: `torus_route`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A header accepted on a clock edge (in_valid_i and in_ready_o both high) gives its result on out_valid_o after that same edge. in_ready_o equals !out_valid_o or out_ready_i.
- R3: While out_valid_o is high and out_ready_i is low, out_valid_o, out_port_o, out_vc_o and out_dl_o hold their values.
- R4: Port codes are 0 local, 1 X plus, 2 X minus, 3 Y plus, 4 Y minus, 5 Z plus, 6 Z minus. If the X coordinates differ, the output port is 1 or 2.
- R5: If X matches and Y differs, the port is 3 or 4. If X and Y match and Z differs, the port is 5 or 6.
- R6: In the chosen dimension, with ring size N and forward distance d = (dst - cur) mod N, the plus direction is chosen when d <= N - d. Otherwise the minus direction is chosen, so a tie goes plus.
- R7: If all three coordinates match, the port is 0, out_vc_o is 0 and out_dl_o equals dl_i.
- R8: A hop in the plus direction from coordinate N-1, or in the minus direction from coordinate 0, sets the chosen dimension's bit in out_dl_o (bit 0 X, bit 1 Y, bit 2 Z) and uses lane 1.
- R9: If the dimension of in_port_i differs from the chosen dimension (port 0 counts as injection), that dimension's bit is cleared before any crossing is applied. If the dimensions match, the bit is kept. out_vc_o equals the resulting bit.
- R10: On a non-local hop, out_dl_o differs from dl_i in at most the chosen dimension's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Header valid |
| in_ready_o | output | 1 | Header can be accepted |
| cur_x_i | input | clog2(DIM_X) | Current node X |
| cur_y_i | input | clog2(DIM_Y) | Current node Y |
| cur_z_i | input | clog2(DIM_Z) | Current node Z |
| dst_x_i | input | clog2(DIM_X) | Destination X |
| dst_y_i | input | clog2(DIM_Y) | Destination Y |
| dst_z_i | input | clog2(DIM_Z) | Destination Z |
| in_port_i | input | 3 | Arrival port code, 0 for injection |
| dl_i | input | 3 | Dateline state from header |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_port_o | output | 3 | Selected output port code |
| out_vc_o | output | 1 | Virtual lane for this hop |
| out_dl_o | output | 3 | Updated dateline state |

## Verification
A wrong dimension-select or direction state shows up on out_port_o in the cycle right after the header is accepted, because the block has only one register stage. A dateline bit that is mishandled is harder to see. Clearing the bit wrongly on entry to a dimension, or failing to keep it within a dimension, changes out_vc_o and out_dl_o only on hops that follow a crossing. For that reason the tests carry a set bit into a turn, and also along a continuing hop in the same dimension. Handshake state faults appear as a lost or repeated result while out_ready_i is held low.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
  localparam int unsigned NDIM = 3;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XM    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YM    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZM    = 3'd6
  } port_e;

  // dimension index of a port code; 3 = none (local / injection)
  function automatic logic [1:0] port_dim(logic [2:0] p);
    case (p)
      3'd1, 3'd2: port_dim = 2'd0;
      3'd3, 3'd4: port_dim = 2'd1;
      3'd5, 3'd6: port_dim = 2'd2;
      default:    port_dim = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/ring_step.sv
module ring_step #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] dst_i,
  output logic         need_o,
  output logic         plus_o,
  output logic         wrap_o
);
  localparam logic [W:0]   RING = (W+1)'(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W:0] fwd;
  logic [W:0] bwd;

  always_comb begin
    if (dst_i >= cur_i) fwd = {1'b0, dst_i} - {1'b0, cur_i};
    else                fwd = {1'b0, dst_i} + RING - {1'b0, cur_i};
    bwd    = RING - fwd;
    need_o = (cur_i != dst_i);
    plus_o = (fwd <= bwd);
    wrap_o = plus_o ? (cur_i == LAST) : (cur_i == '0);
  end
endmodule

// File: rtl/route_select.sv
module route_select
  import torus_route_pkg::*;
(
  input  logic [NDIM-1:0] need_i,
  input  logic [NDIM-1:0] plus_i,
  input  logic [NDIM-1:0] wrap_i,
  input  logic [2:0]      in_port_i,
  input  logic [NDIM-1:0] dl_i,
  output logic [2:0]      port_o,
  output logic            vc_o,
  output logic [NDIM-1:0] dl_o
);
  logic [1:0]      dsel;
  logic            any;
  logic [NDIM-1:0] dl_work;

  always_comb begin
    dsel = 2'd0;
    any  = 1'b0;
    // lowest index wins: X, then Y, then Z
    for (int d = NDIM - 1; d >= 0; d--) begin
      if (need_i[d]) begin
        dsel = 2'(d);
        any  = 1'b1;
      end
    end

    dl_work = dl_i;
    if (port_dim(in_port_i) != dsel) dl_work[dsel] = 1'b0;
    if (wrap_i[dsel])                dl_work[dsel] = 1'b1;

    if (any) begin
      port_o = 3'(1 + 2 * dsel) + {2'b00, ~plus_i[dsel]};
      vc_o   = dl_work[dsel];
      dl_o   = dl_work;
    end else begin
      port_o = PORT_LOCAL;
      vc_o   = 1'b0;
      dl_o   = dl_i;
    end
  end
endmodule

// File: rtl/torus_route.sv
module torus_route
  import torus_route_pkg::*;
#(
  parameter int unsigned DIM_X = 8,
  parameter int unsigned DIM_Y = 8,
  parameter int unsigned DIM_Z = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [$clog2(DIM_X)-1:0] cur_x_i,
  input  logic [$clog2(DIM_Y)-1:0] cur_y_i,
  input  logic [$clog2(DIM_Z)-1:0] cur_z_i,
  input  logic [$clog2(DIM_X)-1:0] dst_x_i,
  input  logic [$clog2(DIM_Y)-1:0] dst_y_i,
  input  logic [$clog2(DIM_Z)-1:0] dst_z_i,
  input  logic [2:0]               in_port_i,
  input  logic [2:0]               dl_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [2:0]               out_port_o,
  output logic                     out_vc_o,
  output logic [2:0]               out_dl_o
);
  logic [NDIM-1:0] need, plus, wrap;
  logic [2:0]      nxt_port;
  logic            nxt_vc;
  logic [NDIM-1:0] nxt_dl;
  logic            accept;

  ring_step #(.N(DIM_X)) u_ring_x (
    .cur_i(cur_x_i), .dst_i(dst_x_i),
    .need_o(need[0]), .plus_o(plus[0]), .wrap_o(wrap[0])
  );
  ring_step #(.N(DIM_Y)) u_ring_y (
    .cur_i(cur_y_i), .dst_i(dst_y_i),
    .need_o(need[1]), .plus_o(plus[1]), .wrap_o(wrap[1])
  );
  ring_step #(.N(DIM_Z)) u_ring_z (
    .cur_i(cur_z_i), .dst_i(dst_z_i),
    .need_o(need[2]), .plus_o(plus[2]), .wrap_o(wrap[2])
  );

  route_select u_sel (
    .need_i(need), .plus_i(plus), .wrap_i(wrap),
    .in_port_i(in_port_i), .dl_i(dl_i),
    .port_o(nxt_port), .vc_o(nxt_vc), .dl_o(nxt_dl)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_port_o  <= PORT_LOCAL;
      out_vc_o    <= 1'b0;
      out_dl_o    <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (accept) begin
        out_port_o <= nxt_port;
        out_vc_o   <= nxt_vc;
        out_dl_o   <= nxt_dl;
      end
    end
  end
endmodule

// File: rtl/torus_route_chk.sv
module torus_route_chk #(
  parameter int unsigned DIM_X = 8,
  parameter int unsigned DIM_Y = 8,
  parameter int unsigned DIM_Z = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic [$clog2(DIM_X)-1:0] cur_x_i,
  input logic [$clog2(DIM_Y)-1:0] cur_y_i,
  input logic [$clog2(DIM_Z)-1:0] cur_z_i,
  input logic [$clog2(DIM_X)-1:0] dst_x_i,
  input logic [$clog2(DIM_Y)-1:0] dst_y_i,
  input logic [$clog2(DIM_Z)-1:0] dst_z_i,
  input logic [2:0]               in_port_i,
  input logic [2:0]               dl_i,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [2:0]               out_port_o,
  input logic                     out_vc_o,
  input logic [2:0]               out_dl_o
);
  logic acc, at_home;
  logic [1:0] odim;
  assign acc     = in_valid_i && in_ready_o;
  assign at_home = (cur_x_i == dst_x_i) && (cur_y_i == dst_y_i) && (cur_z_i == dst_z_i);
  assign odim    = 2'((out_port_o - 3'd1) >> 1);

  AST_RESULT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o); // R2
  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && in_ready_o) |=> !out_valid_o); // R2
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_port_o)
      && $stable(out_vc_o) && $stable(out_dl_o))); // R3
  AST_X_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cur_x_i != dst_x_i) |=> (out_port_o == 3'd1 || out_port_o == 3'd2)); // R4
  AST_LOCAL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && at_home) |=> (out_port_o == 3'd0 && !out_vc_o && out_dl_o == $past(dl_i))); // R7
  AST_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !at_home) |=> ($countones(out_dl_o ^ $past(dl_i)) <= 1)); // R10
  AST_LANE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_port_o != 3'd0) |-> (out_vc_o == out_dl_o[odim])); // R9
endmodule

bind torus_route torus_route_chk #(.DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .cur_z_i(cur_z_i),
  .dst_x_i(dst_x_i), .dst_y_i(dst_y_i), .dst_z_i(dst_z_i),
  .in_port_i(in_port_i), .dl_i(dl_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_port_o(out_port_o), .out_vc_o(out_vc_o),
  .out_dl_o(out_dl_o)
);

// File: tb/test_torus_route.sv
module test_torus_route;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [2:0] cur_x_i = '0, dst_x_i = '0;
  logic [2:0] cur_y_i = '0, dst_y_i = '0;
  logic [1:0] cur_z_i = '0, dst_z_i = '0;
  logic [2:0] in_port_i = '0;
  logic [2:0] dl_i = '0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic [2:0] out_port_o;
  logic       out_vc_o;
  logic [2:0] out_dl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  torus_route #(.DIM_X(8), .DIM_Y(8), .DIM_Z(4)) i_torus_route (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int cx, cy, cz, dx, dy, dz, inp, dl);
    cur_x_i = 3'(cx); cur_y_i = 3'(cy); cur_z_i = 2'(cz);
    dst_x_i = 3'(dx); dst_y_i = 3'(dy); dst_z_i = 2'(dz);
    in_port_i = 3'(inp); dl_i = 3'(dl);
    in_valid_i = 1'b1;
  endtask

  // one header, result checked one edge later
  task automatic route(input string tag, input int cx, cy, cz, dx, dy, dz, inp, dl,
                       input int eport, evc, edl);
    @(negedge clk_i);
    drive(cx, cy, cz, dx, dy, dz, inp, dl);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk({tag, " valid R2"}, int'(out_valid_o), 1);
    chk({tag, " port"}, int'(out_port_o), eport);
    chk({tag, " vc"}, int'(out_vc_o), evc);
    chk({tag, " dl"}, int'(out_dl_o), edl);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", int'(out_valid_o), 0);
    chk("R1 in_ready", int'(in_ready_o), 1);
  endtask

  task automatic t_dim_order;
    route("R4 x plus", 1, 2, 3, 3, 0, 0, 0, 0, 1, 0, 0);
    route("R4 x minus R6", 1, 2, 3, 6, 0, 0, 0, 0, 2, 0, 0);
    route("R5 y turn R9", 4, 3, 1, 4, 5, 0, 1, 1, 3, 0, 1);
    route("R5 z turn clear R9", 4, 5, 1, 4, 5, 2, 3, 4, 5, 0, 0);
  endtask

  task automatic t_tie;
    route("R6 tie plus", 0, 0, 0, 4, 0, 0, 0, 0, 1, 0, 0);
    route("R6 z tie plus", 1, 1, 0, 1, 1, 2, 0, 0, 5, 0, 0);
  endtask

  task automatic t_dateline;
    route("R8 x plus wrap", 7, 0, 0, 1, 0, 0, 0, 0, 1, 1, 1);
    route("R8 x minus wrap", 0, 0, 0, 6, 0, 0, 0, 0, 2, 1, 1);
    route("R8 z minus wrap keep R9", 2, 2, 0, 2, 2, 3, 6, 4, 6, 1, 4);
    route("R9 z keep no cross", 2, 2, 1, 2, 2, 2, 5, 4, 5, 1, 4);
    route("R10 y wrap others kept", 3, 7, 0, 3, 1, 2, 2, 5, 3, 1, 7);
  endtask

  task automatic t_local;
    route("R7 local", 5, 6, 3, 5, 6, 3, 4, 5, 0, 0, 5);
  endtask

  task automatic t_backpressure;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    drive(1, 0, 0, 3, 0, 0, 0, 0);
    @(negedge clk_i);
    chk("R2 bp first valid", int'(out_valid_o), 1);
    chk("R2 bp ready low", int'(in_ready_o), 0);
    drive(0, 2, 0, 0, 7, 0, 0, 0);
    repeat (3) begin
      @(negedge clk_i);
      chk("R3 hold valid", int'(out_valid_o), 1);
      chk("R3 hold port", int'(out_port_o), 1);
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R2 bp second valid", int'(out_valid_o), 1);
    chk("R2 bp second port", int'(out_port_o), 4);
    @(negedge clk_i);
    chk("R2 drained", int'(out_valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_dim_order();
    t_tie();
    t_dateline();
    t_local();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule